// File: doc/BRIEF.md
# Serial Frame Sync Receiver with Word Validation

This block sits behind a demodulator and a bit-clock recovery stage. It takes one data bit for each cycle in which a sample strobe is high. While hunting, it keeps the most recent 12 sampled bits and compares them with a fixed sync pattern, 12'h228 (decimal 552). When they match, it switches to capture and shifts in the next 48 sampled bits as four 12-bit words. Each word arrives MSB first, and word 0 arrives first.

Each word carries a 4-bit identifier in its top nibble and an 8-bit payload below it. The first three words hold sensor data. Each has its own holding buffer, and a buffer is overwritten only when its word carries the expected identifier. The fourth word is reserved and is thrown away. The payload of word 0 always drives an LED bus. A debounced push button steps the numeric display through the other held words.

A status flag reports whether the most recent frame delivered all three sensor words intact.

Top module: `frame_sync_rx`

## Requirements
- R1: Capture starts only when the last 12 strobed bits, oldest first, equal 12'h228. A 12-bit pattern that differs from it in any bit starts nothing.
- R2: After sync, exactly 48 further strobed bits are taken, MSB first. Word k occupies bits [47-12k : 36-12k] of the received order. Held word k appears on `held_words[12k +: 12]`.
- R3: The identifier of word k is bits [11:8], and for word k (k = 0, 1, 2) it must equal k+1. Bits [7:0] are the payload.
- R4: A sensor word with the correct identifier replaces its held value one cycle after the frame's last bit. A word with a wrong identifier leaves its held value unchanged.
- R5: The fourth (reserved) word affects no output, whatever its value or identifier.
- R6: During capture, the sync value inside the data does not restart the frame.
- R7: After 48 bits the receiver hunts again, so a sync pattern that follows a frame immediately is detected.
- R8: `rx_bit` is ignored in every cycle in which `rx_stb` is low.
- R9: `led_word` always equals the payload (bits [7:0]) of held word 0.
- R10: Each debounced rising edge of the button advances `disp_sel` through 0, 1, 0, … . `disp_word` shows held word `disp_sel`+1. Releasing the button does not advance the selection.
- R11: A button level that lasts fewer than DEBOUNCE_CYC cycles has no effect.
- R12: `frame_clean` is updated at the end of each frame. It is 1 when all three sensor words passed their identifier check and 0 otherwise.
- R13: After reset, the held words are zero, `disp_sel` is 0 and `frame_clean` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit | input | 1 | Demodulated serial data |
| rx_stb | input | 1 | High for one cycle when `rx_bit` holds a valid sample |
| btn_raw | input | 1 | Unsynchronised push button, high when pressed |
| held_words | output | 36 | Held sensor words; word k is at [12k +: 12] |
| led_word | output | 8 | Payload of held word 0 |
| disp_word | output | 12 | Held word chosen by the button |
| disp_sel | output | 1 | Index of the chosen word, minus one |
| frame_clean | output | 1 | All sensor words of the last frame were valid |

## Verification
The hardest situation to reach from the ports is a frame whose payload itself carries the sync value while the receiver is capturing. A receiver that wrongly re-armed would realign silently and still update some buffers. The stimulus therefore places 12'h228 inside data words, including the reserved slot, and checks every buffer against values worked out from the identifier rules. Frames that mix good and bad identifiers come in sequence, so each check depends on the held values left by earlier frames. Back-to-back frames with no idle bits confirm that hunting resumes at once.

// File: rtl/frame_rx_pkg.sv
// Package: shared types and helpers for the frame sync receiver.
// Assumes words carry their identifier in the most significant bits.
package frame_rx_pkg;

    typedef enum logic {
        ST_HUNT    = 1'b0,
        ST_CAPTURE = 1'b1
    } hunt_state_e;

    // Identifier expected in sensor slot k (slots are numbered from 0).
    function automatic int unsigned slot_id(input int unsigned k);
        return k + 1;
    endfunction

endpackage

// File: rtl/fs_hunter.sv
// Module: fs_hunter
// Hunts for the sync pattern in a sliding window of strobed bits, then
// shifts in one frame of FRAME_W bits. When the frame is complete it
// emits a one-cycle strobe together with the sensor part of the frame.
// Assumes rx_bit is meaningful only while rx_stb is high.
module fs_hunter
    import frame_rx_pkg::*;
#(
    parameter int          WORD_W  = 12,
    parameter int          FRAME_W = 48,
    parameter int          SENS_W  = 36,
    parameter logic [11:0] SYNC    = 12'h228
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    input  logic              rx_stb,
    output logic              frame_stb,
    output logic [SENS_W-1:0] frame_data,
    output logic              capturing
);

    localparam int                CNT_W    = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(FRAME_W - 1);

    hunt_state_e         state;
    logic [WORD_W-2:0]   window;
    logic [FRAME_W-2:0]  cap;
    logic [CNT_W-1:0]    cnt;
    logic [WORD_W-1:0]   win_next;
    logic [FRAME_W-1:0]  cap_next;

    // Purpose: form the candidate window and shift value for this strobe.
    always_comb begin
        win_next = {window, rx_bit};
        cap_next = {cap, rx_bit};
    end

    // Purpose: hunt/capture sequencing with sync matching off during capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_HUNT;
            window     <= '0;
            cap        <= '0;
            cnt        <= '0;
            frame_stb  <= 1'b0;
            frame_data <= '0;
        end else begin
            frame_stb <= 1'b0;
            if (rx_stb) begin
                case (state)
                    ST_HUNT: begin
                        if (win_next == WORD_W'(SYNC)) begin
                            state  <= ST_CAPTURE;
                            cnt    <= '0;
                            window <= '0;
                        end else begin
                            window <= win_next[WORD_W-2:0];
                        end
                    end
                    ST_CAPTURE: begin
                        cap <= cap_next[FRAME_W-2:0];
                        if (cnt == LAST_BIT) begin
                            state      <= ST_HUNT;
                            frame_stb  <= 1'b1;
                            frame_data <= cap_next[FRAME_W-1 -: SENS_W];
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_HUNT;
                endcase
            end
        end
    end

    assign capturing = (state == ST_CAPTURE);

endmodule

// File: rtl/fs_word_gate.sv
// Module: fs_word_gate
// Checks the identifier of each sensor word of a finished frame and
// loads only the words that pass into their holding buffers. It also
// records whether every sensor word of the frame passed.
// Assumes frame_data holds sensor slot 0 in its most significant word.
module fs_word_gate
    import frame_rx_pkg::*;
#(
    parameter int WORD_W     = 12,
    parameter int ID_W       = 4,
    parameter int NUM_SENSOR = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frame_stb,
    input  logic [NUM_SENSOR*WORD_W-1:0] frame_data,
    output logic [NUM_SENSOR*WORD_W-1:0] held_words,
    output logic                         frame_clean
);

    localparam int SENS_W = NUM_SENSOR * WORD_W;

    logic [NUM_SENSOR-1:0] id_ok;

    for (genvar k = 0; k < NUM_SENSOR; k++) begin : g_slot
        logic [WORD_W-1:0] slot_word;

        // Purpose: pick slot k out of the frame and compare its identifier.
        always_comb begin
            slot_word = frame_data[SENS_W-1-k*WORD_W -: WORD_W];
            id_ok[k]  = (slot_word[WORD_W-1 -: ID_W] == ID_W'(slot_id(k)));
        end

        // Purpose: load the buffer for slot k only when its word is valid.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held_words[k*WORD_W +: WORD_W] <= '0;
            end else if (frame_stb && id_ok[k]) begin
                held_words[k*WORD_W +: WORD_W] <= slot_word;
            end
        end
    end

    // Purpose: record whether the whole frame was clean.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_clean <= 1'b0;
        end else if (frame_stb) begin
            frame_clean <= &id_ok;
        end
    end

endmodule

// File: rtl/fs_btn_select.sv
// Module: fs_btn_select
// Synchronises and debounces a push button, and steps a selection
// index on each debounced press. Releases are ignored.
// Assumes btn_raw is asynchronous and high while pressed.
module fs_btn_select #(
    parameter int DEBOUNCE_CYC = 16,
    parameter int NUM_SEL      = 2,
    parameter int SEL_W        = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             btn_raw,
    output logic [SEL_W-1:0] sel,
    output logic             btn_rise
);

    localparam int               DCNT_W  = $clog2(DEBOUNCE_CYC + 1);
    localparam logic [DCNT_W-1:0] DLIM   = DCNT_W'(DEBOUNCE_CYC - 1);
    localparam logic [SEL_W-1:0] SEL_TOP = SEL_W'(NUM_SEL - 1);

    logic              sync1, sync2;
    logic              stable, stable_q;
    logic [DCNT_W-1:0] dcnt;

    // Purpose: bring the button into the clock domain with two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= btn_raw;
            sync2 <= sync1;
        end
    end

    // Purpose: accept a new level only after it has held DEBOUNCE_CYC cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable   <= 1'b0;
            stable_q <= 1'b0;
            dcnt     <= '0;
        end else begin
            stable_q <= stable;
            if (sync2 == stable) begin
                dcnt <= '0;
            end else if (dcnt == DLIM) begin
                stable <= sync2;
                dcnt   <= '0;
            end else begin
                dcnt <= dcnt + 1'b1;
            end
        end
    end

    assign btn_rise = stable & ~stable_q;

    // Purpose: step the selection on each debounced press, wrapping at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= '0;
        end else if (btn_rise) begin
            sel <= (sel == SEL_TOP) ? '0 : sel + 1'b1;
        end
    end

endmodule

// File: rtl/frame_sync_rx.sv
// Module: frame_sync_rx (top)
// Frame sync receiver: finds the sync pattern in the strobed bit stream,
// captures the following words, keeps the sensor words whose identifiers
// are valid, and routes them to the LED and numeric-display outputs.
// Assumes one bit per rx_stb pulse, MSB first within each word.
module frame_sync_rx #(
    parameter int          WORD_W       = 12,
    parameter int          ID_W         = 4,
    parameter int          NUM_WORDS    = 4,
    parameter int          NUM_SENSOR   = 3,
    parameter logic [11:0] SYNC_PATTERN = 12'h228,
    parameter int          DEBOUNCE_CYC = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rx_bit,
    input  logic                         rx_stb,
    input  logic                         btn_raw,
    output logic [NUM_SENSOR*WORD_W-1:0] held_words,
    output logic [WORD_W-ID_W-1:0]       led_word,
    output logic [WORD_W-1:0]            disp_word,
    output logic [((NUM_SENSOR-1) > 1 ? $clog2(NUM_SENSOR-1) : 1)-1:0] disp_sel,
    output logic                         frame_clean
);

    localparam int FRAME_W = WORD_W * NUM_WORDS;
    localparam int SENS_W  = WORD_W * NUM_SENSOR;
    localparam int NUM_SEL = NUM_SENSOR - 1;
    localparam int SEL_W   = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1;

    logic              frame_stb;
    logic [SENS_W-1:0] frame_data;
    logic              capturing;
    logic              btn_rise;

    fs_hunter #(
        .WORD_W (WORD_W),
        .FRAME_W(FRAME_W),
        .SENS_W (SENS_W),
        .SYNC   (SYNC_PATTERN)
    ) u_hunter (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_bit    (rx_bit),
        .rx_stb    (rx_stb),
        .frame_stb (frame_stb),
        .frame_data(frame_data),
        .capturing (capturing)
    );

    fs_word_gate #(
        .WORD_W    (WORD_W),
        .ID_W      (ID_W),
        .NUM_SENSOR(NUM_SENSOR)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_stb  (frame_stb),
        .frame_data (frame_data),
        .held_words (held_words),
        .frame_clean(frame_clean)
    );

    fs_btn_select #(
        .DEBOUNCE_CYC(DEBOUNCE_CYC),
        .NUM_SEL     (NUM_SEL),
        .SEL_W       (SEL_W)
    ) u_btn (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_raw (btn_raw),
        .sel     (disp_sel),
        .btn_rise(btn_rise)
    );

    // Purpose: route word 0's payload to the LEDs, and the chosen word to the display.
    always_comb begin
        led_word  = held_words[WORD_W-ID_W-1:0];
        disp_word = held_words[WORD_W*(int'(disp_sel) + 1) +: WORD_W];
    end

endmodule

// File: rtl/fs_rx_chk.sv
// Module: fs_rx_chk
// Assertion checker for frame_sync_rx, attached by the bind below.
// Assumes it observes the top-level ports and the internal handshake nets.
module fs_rx_chk #(
    parameter int WORD_W     = 12,
    parameter int ID_W       = 4,
    parameter int NUM_SENSOR = 3,
    parameter int SEL_W      = 1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         rx_stb,
    input logic                         capturing,
    input logic                         frame_stb,
    input logic                         btn_rise,
    input logic [NUM_SENSOR*WORD_W-1:0] held_words,
    input logic                         frame_clean,
    input logic [SEL_W-1:0]             disp_sel
);

    // R4: buffers move only on a completed frame
    a_r4_hold_without_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(held_words));

    // R12: the status flag moves only on a completed frame
    a_r12_status_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(frame_clean));

    // R6 / R8: capture cannot end or restart without a strobed bit
    a_r6_capture_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (capturing && !rx_stb) |=> capturing);

    // R2: a frame completes exactly as capture stops, on a strobe
    a_r2_frame_ends_capture: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> (!capturing && $past(capturing) && $past(rx_stb)));

    // R10: the selection advances only on a debounced press
    a_r10_sel_on_press: assert property (@(posedge clk) disable iff (!rst_n)
        !btn_rise |=> $stable(disp_sel));

    for (genvar k = 0; k < NUM_SENSOR; k++) begin : g_id
        // R3: a non-empty buffer always carries its slot's identifier
        a_r3_held_id: assert property (@(posedge clk) disable iff (!rst_n)
            (held_words[k*WORD_W +: WORD_W] != '0) |->
            (held_words[k*WORD_W + WORD_W - 1 -: ID_W] == ID_W'(k + 1)));
    end

endmodule

bind frame_sync_rx fs_rx_chk #(
    .WORD_W    (WORD_W),
    .ID_W      (ID_W),
    .NUM_SENSOR(NUM_SENSOR),
    .SEL_W     (SEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_stb     (rx_stb),
    .capturing  (capturing),
    .frame_stb  (frame_stb),
    .btn_rise   (btn_rise),
    .held_words (held_words),
    .frame_clean(frame_clean),
    .disp_sel   (disp_sel)
);

// File: tb/tb_frame_sync_rx.sv
`timescale 1ns/1ps
module tb_frame_sync_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_bit = 1'b0;
    logic        rx_stb = 1'b0;
    logic        btn_raw = 1'b0;
    logic [35:0] held_words;
    logic [7:0]  led_word;
    logic [11:0] disp_word;
    logic [0:0]  disp_sel;
    logic        frame_clean;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    frame_sync_rx dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_bit     (rx_bit),
        .rx_stb     (rx_stb),
        .btn_raw    (btn_raw),
        .held_words (held_words),
        .led_word   (led_word),
        .disp_word  (disp_word),
        .disp_sel   (disp_sel),
        .frame_clean(frame_clean)
    );

    // Frames after sync (word0 first); expected held {w2,w1,w0}; expected clean bit.
    localparam logic [47:0] VEC_FRAME [6] = '{
        48'h1AB_2CD_3EF_400,
        48'h111_5FF_322_000,
        48'h0FF_200_9FF_FFF,
        48'h1C3_2A5_35A_228,
        48'h100_2FF_300_E12,
        48'h228_228_328_4AA
    };
    localparam logic [35:0] VEC_HELD [6] = '{
        36'h3EF_2CD_1AB,
        36'h322_2CD_111,
        36'h322_200_111,
        36'h35A_2A5_1C3,
        36'h300_2FF_100,
        36'h328_228_100
    };
    localparam logic [5:0] VEC_CLEAN = 6'b011001;

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One strobed bit; rx_bit is inverted during the non-strobe cycle (R8).
    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_bit = b;
        rx_stb = 1'b1;
        @(negedge clk);
        rx_stb = 1'b0;
        rx_bit = ~b;
    endtask

    task automatic send_word(input logic [11:0] w);
        for (int i = 11; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic send_frame(input logic [47:0] f);
        send_word(12'h228);
        for (int i = 47; i >= 0; i--) send_bit(f[i]);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic press(input int cycles);
        @(negedge clk);
        btn_raw = 1'b1;
        repeat (cycles) @(negedge clk);
        btn_raw = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: reset state
        chk("R13 held", 48'(held_words), 48'h0);
        chk("R13 sel", 48'(disp_sel), 48'h0);
        chk("R13 clean", 48'(frame_clean), 48'h0);

        // Table walk: R2 R3 R4 R5 R6 R8 R9 R12
        for (int v = 0; v < 6; v++) begin
            for (int z = 0; z < 5; z++) send_bit(1'b0);
            send_frame(VEC_FRAME[v]);
            settle();
            chk($sformatf("R4 R2 R3 R5 R6 R8 held vec%0d", v), 48'(held_words), 48'(VEC_HELD[v]));
            chk($sformatf("R12 clean vec%0d", v), 48'(frame_clean), 48'(VEC_CLEAN[v]));
            chk($sformatf("R9 led vec%0d", v), 48'(led_word), 48'(VEC_HELD[v][7:0]));
        end

        // R1: near-miss sync followed by valid-looking words changes nothing
        for (int z = 0; z < 12; z++) send_bit(1'b0);
        send_word(12'h229);
        send_word(12'h1FF); send_word(12'h2FF); send_word(12'h3FF); send_word(12'h4FF);
        settle();
        chk("R1 near-miss held", 48'(held_words), 48'h328_228_100);
        chk("R1 near-miss clean", 48'(frame_clean), 48'h0);

        // R7: two frames back to back with no gap bits
        for (int z = 0; z < 12; z++) send_bit(1'b0);
        send_frame(48'h1AA_2BB_3CC_4DD);
        send_frame(48'h155_266_377_488);
        settle();
        chk("R7 back-to-back held", 48'(held_words), 48'h377_266_155);
        chk("R7 back-to-back clean", 48'(frame_clean), 48'h1);
        chk("R9 led", 48'(led_word), 48'h55);

        // R10 / R11: display selection
        chk("R10 initial disp", 48'(disp_word), 48'h266);
        press(40);
        chk("R10 sel after press", 48'(disp_sel), 48'h1);
        chk("R10 disp after press", 48'(disp_word), 48'h377);
        press(3);
        chk("R11 glitch ignored", 48'(disp_sel), 48'h1);
        press(40);
        chk("R10 wrap sel", 48'(disp_sel), 48'h0);
        chk("R10 wrap disp", 48'(disp_word), 48'h266);

        // R13: reset in the middle of a capture
        send_word(12'h228);
        for (int i = 0; i < 7; i++) send_bit(1'b1);
        press(40);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 held after reset", 48'(held_words), 48'h0);
        chk("R13 sel after reset", 48'(disp_sel), 48'h0);
        chk("R13 clean after reset", 48'(frame_clean), 48'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule